// File: doc/BRIEF.md
# Cache Line Coherence State Updater

This block decides what happens to one data-cache line when an access touches it. For each access the caller gives the kind of access and the current coherence state of the line (invalid, shared, exclusive or modified). It also gives the attributes sampled for that access. These are an external policy bit that chooses write-back or write-through, the page write-through bit, the cacheability indication the core drives, and the cache-enable indication from the system. The block answers with the next state for the line. It also says whether the bus must carry a single write-through cycle of 1 to 8 bytes or a 32-byte burst writeback.

A shared line behaves as write-through: every write to it also goes to memory. Exclusive and modified lines behave as write-back. The policy bit and the page write-through bit together decide, for each access, whether a filled or written line may be held exclusively. Tag lookup, data storage and bus sequencing belong to the surrounding cache. Results are registered and appear one clock after the request.

Top module: `mesi_line_ctrl`

## Requirements
- R1: The state encoding is invalid=0, shared=1, exclusive=2, modified=3. The access kind encoding is read-miss fill=0, write hit=1, write miss=2, inquire=3, internal snoop=4, flush=5, writeback-invalidate=6, no-op=7. A request is taken when `acc_valid` is high at a rising edge. Its result is on the outputs, with `res_valid` high, from that edge until the next one. While `res_valid` is low, both bus request outputs stay low.
- R2: On a read-miss fill with `cache_enable` and `line_cacheable` both high, the line becomes exclusive when `policy_wb` is high and `page_wt` is low.
- R3: On a read-miss fill with `cache_enable` and `line_cacheable` both high, the line becomes shared when `policy_wb` is low or `page_wt` is high.
- R4: On a read-miss fill with `cache_enable` or `line_cacheable` low, the line stays invalid. No bus request is raised by any read-miss fill.
- R5: A write hit to a shared line raises a write-through request. The line becomes exclusive when `policy_wb` is high and `page_wt` is low; otherwise it stays shared.
- R6: A write hit to an exclusive line goes to modified with no bus request when `policy_wb` is high and `page_wt` is low. Otherwise the line drops to shared and a write-through request is raised.
- R7: A write hit to a modified line keeps it modified and raises no bus request.
- R8: A write miss raises a write-through request and leaves the state unchanged. A write hit reported against an invalid line is handled the same way.
- R9: An inquire or internal snoop that finds a modified line raises a burst writeback. After an inquire or snoop, a valid line ends invalid when `snoop_inval` is high and shared otherwise. An invalid line stays invalid. Neither kind raises a write-through request.
- R10: Flush and writeback-invalidate raise a burst writeback only for a modified line, and always leave the line invalid.
- R11: The no-op kind returns the current state unchanged and raises no bus request. The two bus request outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request strobe |
| acc_kind | input | 3 | Access kind code |
| cur_state | input | 2 | Present line state |
| policy_wb | input | 1 | Sampled write-back policy bit |
| page_wt | input | 1 | Page write-through attribute |
| line_cacheable | input | 1 | Core's cacheability indication |
| cache_enable | input | 1 | System cache-enable indication |
| snoop_inval | input | 1 | Inquire or snoop also invalidates |
| res_valid | output | 1 | Result strobe |
| res_state | output | 2 | Next line state |
| req_writethru | output | 1 | Single write-through cycle needed |
| req_burst_wb | output | 1 | 32-byte burst writeback needed |

## Verification
Every result is due exactly one rising edge after the edge that takes the request. Nothing else is in the path. The bench drives each request on a falling edge and samples state, both requests and `res_valid` 2 ns after the next rising edge. It drops the strobe at the following falling edge, so the idle check lands on the edge after that. Each scenario task applies its own input combinations and compares against values written from the requirements.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   localparam int STATE_BITS = 2;
   localparam int KIND_BITS  = 3;

   typedef enum logic [STATE_BITS-1:0] {
      LS_INV  = 2'd0,
      LS_SHR  = 2'd1,
      LS_EXC  = 2'd2,
      LS_MOD  = 2'd3
   } line_st_t;

   typedef enum logic [KIND_BITS-1:0] {
      AK_RDFILL = 3'd0,
      AK_WRHIT  = 3'd1,
      AK_WRMISS = 3'd2,
      AK_INQ    = 3'd3,
      AK_SNOOP  = 3'd4,
      AK_FLUSH  = 3'd5,
      AK_WBINV  = 3'd6,
      AK_NOP    = 3'd7
   } acc_kind_t;

   typedef struct packed {
      line_st_t st;
      logic     wthru;
      logic     burst;
   } upd_res_t;
endpackage

// File: rtl/mesi_policy_eval.sv
module mesi_policy_eval (
   input  logic policy_wb,
   input  logic page_wt,
   input  logic line_cacheable,
   input  logic cache_enable,
   output logic hold_excl,
   output logic may_alloc
);
   // exclusive ownership only when the policy asks for write-back
   // and the page does not force write-through
   always_comb begin
      hold_excl = policy_wb & ~page_wt;
      may_alloc = line_cacheable & cache_enable;
   end
endmodule

// File: rtl/mesi_state_next.sv
module mesi_state_next
   import mesi_pkg::*;
(
   input  acc_kind_t kind,
   input  line_st_t  cur,
   input  logic      hold_excl,
   input  logic      may_alloc,
   input  logic      snoop_inval,
   output upd_res_t  res
);
   always_comb begin
      res.st    = cur;
      res.wthru = 1'b0;
      res.burst = 1'b0;
      unique case (kind)
         AK_RDFILL: begin
            if (!may_alloc)     res.st = LS_INV;
            else if (hold_excl) res.st = LS_EXC;
            else                res.st = LS_SHR;
         end
         AK_WRHIT: begin
            unique case (cur)
               LS_SHR: begin
                  res.wthru = 1'b1;
                  res.st    = hold_excl ? LS_EXC : LS_SHR;
               end
               LS_EXC: begin
                  res.wthru = ~hold_excl;
                  res.st    = hold_excl ? LS_MOD : LS_SHR;
               end
               LS_MOD:  res.st    = LS_MOD;
               default: res.wthru = 1'b1;
            endcase
         end
         AK_WRMISS: res.wthru = 1'b1;
         AK_INQ, AK_SNOOP: begin
            res.burst = (cur == LS_MOD);
            if (cur != LS_INV) res.st = snoop_inval ? LS_INV : LS_SHR;
         end
         AK_FLUSH, AK_WBINV: begin
            res.burst = (cur == LS_MOD);
            res.st    = LS_INV;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int STATE_W   = 2,
   parameter int KIND_W    = 3,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic [KIND_W-1:0]  acc_kind,
   input  logic [STATE_W-1:0] cur_state,
   input  logic               policy_wb,
   input  logic               page_wt,
   input  logic               line_cacheable,
   input  logic               cache_enable,
   input  logic               snoop_inval,
   output logic               res_valid,
   output logic [STATE_W-1:0] res_state,
   output logic               req_writethru,
   output logic               req_burst_wb
);
   localparam int N_STATES = 1 << STATE_W;
   localparam int N_KINDS  = 1 << KIND_W;

   if (STATE_W != STATE_BITS || N_STATES != 4) begin : g_bad_state_w
      $error("mesi_line_ctrl: STATE_W must be 2");
   end
   if (KIND_W != KIND_BITS || N_KINDS != 8) begin : g_bad_kind_w
      $error("mesi_line_ctrl: KIND_W must be 3");
   end

   logic     hold_excl, may_alloc;
   upd_res_t comb_res;

   mesi_policy_eval u_policy (
      .policy_wb      (policy_wb),
      .page_wt        (page_wt),
      .line_cacheable (line_cacheable),
      .cache_enable   (cache_enable),
      .hold_excl      (hold_excl),
      .may_alloc      (may_alloc)
   );

   mesi_state_next u_next (
      .kind        (acc_kind_t'(acc_kind)),
      .cur         (line_st_t'(cur_state)),
      .hold_excl   (hold_excl),
      .may_alloc   (may_alloc),
      .snoop_inval (snoop_inval),
      .res         (comb_res)
   );

   if (REG_OUT) begin : g_reg
      logic     vld_q;
      upd_res_t res_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
         end else begin
            vld_q <= acc_valid;
            if (acc_valid) res_q <= comb_res;
         end
      end
      assign res_valid     = vld_q;
      assign res_state     = res_q.st;
      assign req_writethru = vld_q & res_q.wthru;
      assign req_burst_wb  = vld_q & res_q.burst;

      AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid |=> res_valid); // R1
      AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !res_valid |-> !req_writethru && !req_burst_wb); // R1
      AST_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid && $past(acc_kind == AK_RDFILL && line_cacheable && cache_enable
                            && policy_wb && !page_wt)
         |-> res_state == LS_EXC); // R2
      AST_FILL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid && $past(acc_kind == AK_RDFILL && !(line_cacheable && cache_enable))
         |-> res_state == LS_INV && !req_writethru && !req_burst_wb); // R4
      AST_MOD_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid && $past(acc_kind == AK_WRHIT && cur_state == LS_MOD)
         |-> res_state == LS_MOD && !req_writethru); // R7
      AST_BURST_NEEDS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
         req_burst_wb |-> $past(cur_state) == LS_MOD); // R9
      AST_FLUSH_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid && $past(acc_kind == AK_FLUSH || acc_kind == AK_WBINV)
         |-> res_state == LS_INV); // R10
      AST_ONE_BUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         !(req_writethru && req_burst_wb)); // R11
   end else begin : g_comb
      assign res_valid     = acc_valid;
      assign res_state     = comb_res.st;
      assign req_writethru = acc_valid & comb_res.wthru;
      assign req_burst_wb  = acc_valid & comb_res.burst;
      always_comb begin
         if (rst_n) AST_ONE_BUS_REQ_C: assert (!(req_writethru && req_burst_wb)); // R11
      end
   end
endmodule

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;
   localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
   localparam logic [2:0] K_RD = 3'd0, K_WH = 3'd1, K_WM = 3'd2, K_INQ = 3'd3,
                          K_SNP = 3'd4, K_FL = 3'd5, K_WBI = 3'd6, K_NOP = 3'd7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0;
   logic [2:0] acc_kind = '0;
   logic [1:0] cur_state = '0;
   logic policy_wb = 1'b0, page_wt = 1'b0, line_cacheable = 1'b0;
   logic cache_enable = 1'b0, snoop_inval = 1'b0;
   logic res_valid, req_writethru, req_burst_wb;
   logic [1:0] res_state;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   mesi_line_ctrl u_mesi_line_ctrl (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
      .cur_state(cur_state), .policy_wb(policy_wb), .page_wt(page_wt),
      .line_cacheable(line_cacheable), .cache_enable(cache_enable),
      .snoop_inval(snoop_inval), .res_valid(res_valid), .res_state(res_state),
      .req_writethru(req_writethru), .req_burst_wb(req_burst_wb)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: {valid,state,wt,bw} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic access(input logic [2:0] k, input logic [1:0] cs,
                         input logic pol, input logic pwt, input logic cch,
                         input logic ken, input logic inv,
                         input logic [1:0] xs, input logic xwt, input logic xbw,
                         input string tag);
      @(negedge clk);
      acc_kind = k; cur_state = cs; policy_wb = pol; page_wt = pwt;
      line_cacheable = cch; cache_enable = ken; snoop_inval = inv;
      acc_valid = 1'b1;
      @(posedge clk); #2;
      check(tag, {res_valid, res_state, req_writethru, req_burst_wb} == 5'b0 ? 4'b0 : 4'b0, 4'b0);
      checks--;
      checks++;
      if ({res_valid, res_state, req_writethru, req_burst_wb} !== {1'b1, xs, xwt, xbw}) begin
         fails++;
         $display("FAIL %s: {valid,state,wt,bw} actual=%b expected=%b", tag,
                  {res_valid, res_state, req_writethru, req_burst_wb}, {1'b1, xs, xwt, xbw});
      end
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic t_reset;
      @(posedge clk); #2;
      check("R1 reset", {res_valid, 1'b0, req_writethru, req_burst_wb}, 4'b0);
   endtask

   task automatic t_fill;
      access(K_RD, I, 1, 0, 1, 1, 0, E, 0, 0, "R2 fill wb");
      access(K_RD, I, 0, 0, 1, 1, 0, S, 0, 0, "R3 fill policy wt");
      access(K_RD, I, 1, 1, 1, 1, 0, S, 0, 0, "R3 fill page wt");
      access(K_RD, I, 1, 0, 1, 0, 0, I, 0, 0, "R4 fill no ken");
      access(K_RD, I, 1, 0, 0, 1, 0, I, 0, 0, "R4 fill not cacheable");
   endtask

   task automatic t_write_hit;
      access(K_WH, S, 1, 0, 1, 1, 0, E, 1, 0, "R5 shared hit wb");
      access(K_WH, S, 0, 0, 1, 1, 0, S, 1, 0, "R5 shared hit wt");
      access(K_WH, E, 1, 0, 1, 1, 0, M, 0, 0, "R6 excl hit wb");
      access(K_WH, E, 1, 1, 1, 1, 0, S, 1, 0, "R6 excl hit page wt");
      access(K_WH, M, 0, 1, 1, 1, 0, M, 0, 0, "R7 mod hit");
      access(K_WH, M, 1, 0, 1, 1, 0, M, 0, 0, "R7 mod hit wb");
   endtask

   task automatic t_write_miss;
      access(K_WM, I, 1, 0, 1, 1, 0, I, 1, 0, "R8 write miss");
      access(K_WH, I, 1, 0, 1, 1, 0, I, 1, 0, "R8 hit on invalid");
   endtask

   task automatic t_snoop;
      access(K_INQ, M, 0, 0, 1, 1, 1, I, 0, 1, "R9 inq mod inval");
      access(K_INQ, M, 0, 0, 1, 1, 0, S, 0, 1, "R9 inq mod keep");
      access(K_SNP, E, 0, 0, 1, 1, 0, S, 0, 0, "R9 snoop excl keep");
      access(K_SNP, S, 0, 0, 1, 1, 1, I, 0, 0, "R9 snoop shared inval");
      access(K_INQ, I, 0, 0, 1, 1, 0, I, 0, 0, "R9 inq invalid");
      access(K_SNP, M, 1, 0, 1, 1, 1, I, 0, 1, "R9 snoop mod inval");
   endtask

   task automatic t_flush;
      access(K_FL,  M, 0, 0, 1, 1, 0, I, 0, 1, "R10 flush mod");
      access(K_FL,  E, 0, 0, 1, 1, 0, I, 0, 0, "R10 flush excl");
      access(K_WBI, M, 0, 0, 1, 1, 0, I, 0, 1, "R10 wbinv mod");
      access(K_WBI, S, 0, 0, 1, 1, 0, I, 0, 0, "R10 wbinv shared");
   endtask

   task automatic t_nop_idle;
      access(K_NOP, E, 1, 0, 1, 1, 1, E, 0, 0, "R11 nop excl");
      access(K_NOP, M, 1, 0, 1, 1, 1, M, 0, 0, "R11 nop mod");
      @(posedge clk); #2;
      check("R1 idle after strobe", {res_valid, 1'b0, req_writethru, req_burst_wb}, 4'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_fill();
      t_write_hit();
      t_write_miss();
      t_snoop();
      t_flush();
      t_nop_idle();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R1 watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule